// File: doc/BRIEF.md
# Multi-Stage Decimating FIR Engine

This block filters and decimates a stream of signed samples that arrive at one eighth of the master clock. It uses a single time-shared multiply-accumulate unit. The filter is a cascade of one to five decimating FIR stages, and each stage has its own tap count and a power-of-two decimation factor. All stages share one coefficient memory of 108 entries, and each coefficient is 24 bits wide. Software writes coefficients and stage settings through a simple write port. It then writes a stage count to the control address. That write is the commit, and it validates the whole configuration. A rejected configuration raises an error flag and the engine stays idle. An accepted configuration is latched as the active setup, and every sample history and decimation phase is cleared.

Each input sample is widened to 30 bits and pushed into stage 0. When a stage has collected its decimation count of new samples, the MAC walks that stage's taps, one tap per cycle. The saturated 30-bit result is pushed into the next stage. After the last stage, the result is rounded and saturated to a 16-bit word and presented with a one-cycle valid strobe. A sample that arrives while the engine is not in `ST_WAIT` is dropped.

The control FSM has these states:
- `ST_UNCFG`: after reset.
- `ST_CHECK`: one cycle after a commit.
- `ST_FAULT`: rejected configuration.
- `ST_WAIT`: idle and armed.
- `ST_PUSH`: write the pending value into the current stage history.
- `ST_MAC`: one tap per cycle.
- `ST_EMIT`: hand the result on, or output it.

The transitions are:
- A commit in any state leads to `ST_CHECK`.
- `ST_CHECK` goes to `ST_WAIT` when the configuration is valid, and to `ST_FAULT` otherwise.
- `ST_WAIT` goes to `ST_PUSH` on a sample.
- `ST_PUSH` goes to `ST_MAC` when the stage's phase completes, and back to `ST_WAIT` otherwise.
- `ST_MAC` goes to `ST_EMIT` after the last tap.
- `ST_EMIT` goes to `ST_PUSH` for the next stage, or to `ST_WAIT` after the last stage.

Top module: `dfir_decim_engine`

## Requirements
- R1: After reset, `out_valid`, `out_data` and `cfg_err` are 0, and input samples produce no output until a valid configuration is committed.
- R2: The write map is as follows. Address 0..107 writes a 24-bit coefficient. Address 0x80+s (s<5) writes stage s, with the tap count in data[6:0] and log2 of the decimation in data[11:8]. Address 0xC0 takes the stage count from data[2:0] and commits.
- R3: A commit is rejected, with `cfg_err` set to 1 and samples ignored, in any of these cases: the stage count is 0 or above 5; an active stage has 0 taps; the active taps total more than 108; or the sum of the active log2 decimations is 0 or above 8. `cfg_err` stays 1 until the next commit.
- R4: An accepted commit clears `cfg_err`, every sample history and every decimation phase.
- R5: A stage with log2 decimation L produces one result for every 2^L samples pushed into it, on the 2^L-th, the 2·2^L-th push and so on.
- R6: Stage s uses the coefficients at consecutive addresses starting at the sum of the tap counts of stages 0..s-1. Tap k multiplies the k-th most recent sample of that stage, where k=0 is the newest.
- R7: A sample enters as `in_data`·2^14 in 30 bits. Each product is sample·coef shifted arithmetically right by 23, so a coefficient is a Q1.23 value. The stage result is the sum, saturated to the signed 30-bit range.
- R8: The final 30-bit result is rounded half up: 2^13 is added, then the value is shifted arithmetically right by 14.
- R9: The rounded value is saturated to the range -32768..32767.
- R10: Each stage's result feeds the next stage. The output rate is the input rate divided by the product of the stage factors, and this holds up to five stages and a total factor of 256.
- R11: `out_valid` is high for exactly one cycle per output word. `out_data` changes only together with `out_valid`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 8 | Configuration address |
| cfg_data | input | 24 | Configuration write data |
| in_valid | input | 1 | Input sample strobe |
| in_data | input | 16 | Signed input sample |
| out_valid | output | 1 | One-cycle output word strobe |
| out_data | output | 16 | Signed filtered output word |
| cfg_err | output | 1 | Configuration rejected |

## Verification
The hardest situations to reach are the ones deep in the cascade. The last stage of a five-stage chain fires only once per 32 input samples, and a 256-fold single stage fires only once per 256 samples. The directed stimulus therefore streams long runs of identical samples and checks that no word appears before the final sample of each window. The clamp on the 30-bit intermediate value is reached through coefficients whose sum exceeds one, fed with full-scale positive and negative inputs. An odd leftover sample before a recommit shows whether the decimation phase restarts.

// File: rtl/dfir_pkg.sv
package dfir_pkg;
    localparam int ADDR_W = 8;
    localparam logic [ADDR_W-1:0] A_STG  = 8'h80;
    localparam logic [ADDR_W-1:0] A_CTRL = 8'hC0;

    typedef enum logic [2:0] {
        ST_UNCFG,
        ST_CHECK,
        ST_FAULT,
        ST_WAIT,
        ST_PUSH,
        ST_MAC,
        ST_EMIT
    } eng_state_t;
endpackage

// File: rtl/dfir_cfg_check.sv
module dfir_cfg_check #(
    parameter int STG_MAX = 5,
    parameter int TAP_MAX = 108,
    parameter int TAP_W   = 7,
    parameter int LOG_W   = 4,
    parameter int LOG_MAX = 8,
    parameter int CNT_W   = 3
) (
    input  logic [CNT_W-1:0]              n_stg,
    input  logic [STG_MAX-1:0][TAP_W-1:0] taps,
    input  logic [STG_MAX-1:0][LOG_W-1:0] dlog,
    output logic [STG_MAX-1:0][TAP_W-1:0] base,
    output logic                          ok
);
    localparam int SUM_W = TAP_W + CNT_W;
    localparam int LS_W  = LOG_W + CNT_W;

    logic [SUM_W-1:0]   tsum [STG_MAX+1];
    logic [LS_W-1:0]    lsum [STG_MAX+1];
    logic [STG_MAX-1:0] empty_stg;

    assign tsum[0] = '0;
    assign lsum[0] = '0;

    for (genvar s = 0; s < STG_MAX; s++) begin : g_stg
        logic active;
        assign active       = (CNT_W'(s) < n_stg);
        assign tsum[s+1]    = tsum[s] + (active ? SUM_W'(taps[s]) : '0);
        assign lsum[s+1]    = lsum[s] + (active ? LS_W'(dlog[s]) : '0);
        assign base[s]      = TAP_W'(tsum[s]);
        assign empty_stg[s] = active && (taps[s] == '0);
    end

    assign ok = (n_stg != '0)
             && (n_stg <= CNT_W'(STG_MAX))
             && (empty_stg == '0)
             && (tsum[STG_MAX] <= SUM_W'(TAP_MAX))
             && (lsum[STG_MAX] != '0)
             && (lsum[STG_MAX] <= LS_W'(LOG_MAX));
endmodule

// File: rtl/dfir_mac.sv
module dfir_mac #(
    parameter int SMP_W  = 30,
    parameter int COEF_W = 24,
    parameter int GUARD  = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     clear,
    input  logic                     en,
    input  logic signed [SMP_W-1:0]  smp,
    input  logic signed [COEF_W-1:0] coef,
    output logic signed [SMP_W-1:0]  result
);
    localparam int PROD_W = SMP_W + COEF_W;
    localparam int WIDE_W = SMP_W + GUARD;
    localparam int FRAC   = COEF_W - 1;

    logic signed [PROD_W-1:0] prod;
    logic signed [WIDE_W-1:0] acc;
    logic                     fits;

    assign prod = smp * coef;

    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            acc <= '0;
        end else if (en) begin
            acc <= acc + WIDE_W'(prod >>> FRAC);
        end
    end

    // Upper guard bits must all equal the sign of the 30-bit result.
    assign fits = (acc[WIDE_W-1:SMP_W-1] == '0) || (acc[WIDE_W-1:SMP_W-1] == '1);

    always_comb begin
        if (fits) begin
            result = acc[SMP_W-1:0];
        end else if (acc[WIDE_W-1]) begin
            result = {1'b1, {(SMP_W-1){1'b0}}};
        end else begin
            result = {1'b0, {(SMP_W-1){1'b1}}};
        end
    end
endmodule

// File: rtl/dfir_round_sat.sv
module dfir_round_sat #(
    parameter int ACC_W = 30,
    parameter int OUT_W = 16
) (
    input  logic signed [ACC_W-1:0] din,
    output logic signed [OUT_W-1:0] dout
);
    localparam int SH = ACC_W - OUT_W;

    logic signed [ACC_W:0] biased;
    logic signed [OUT_W:0] q;

    assign biased = {din[ACC_W-1], din} + (ACC_W+1)'(1 << (SH - 1));
    assign q      = (OUT_W+1)'(biased >>> SH);

    always_comb begin
        if (q[OUT_W] == q[OUT_W-1]) begin
            dout = q[OUT_W-1:0];
        end else if (q[OUT_W]) begin
            dout = {1'b1, {(OUT_W-1){1'b0}}};
        end else begin
            dout = {1'b0, {(OUT_W-1){1'b1}}};
        end
    end
endmodule

// File: rtl/dfir_decim_engine.sv
module dfir_decim_engine
    import dfir_pkg::*;
#(
    parameter int TAP_MAX = 108,
    parameter int STG_MAX = 5,
    parameter int IN_W    = 16,
    parameter int COEF_W  = 24,
    parameter int ACC_W   = 30,
    parameter int OUT_W   = 16,
    parameter int LOG_MAX = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     cfg_we,
    input  logic [ADDR_W-1:0]        cfg_addr,
    input  logic [COEF_W-1:0]        cfg_data,
    input  logic                     in_valid,
    input  logic signed [IN_W-1:0]   in_data,
    output logic                     out_valid,
    output logic signed [OUT_W-1:0]  out_data,
    output logic                     cfg_err
);
    localparam int TAP_W = $clog2(TAP_MAX + 1);
    localparam int CNT_W = $clog2(STG_MAX + 1);
    localparam int LOG_W = $clog2(LOG_MAX + 1);
    localparam int PH_W  = LOG_MAX;
    localparam int IN_SH = ACC_W - IN_W;

    eng_state_t state, nxt;

    // configuration: written copy and active copy
    logic [COEF_W-1:0]              coef_mem [TAP_MAX];
    logic [STG_MAX-1:0][TAP_W-1:0]  taps_w, taps_a, base_a, base_c;
    logic [STG_MAX-1:0][LOG_W-1:0]  log_w, log_a;
    logic [CNT_W-1:0]               n_w, n_a;
    logic                           cfg_ok;

    // datapath state
    logic signed [ACC_W-1:0] hist [TAP_MAX];
    logic [TAP_W-1:0]        newest [STG_MAX];
    logic [PH_W-1:0]         phase  [STG_MAX];
    logic [CNT_W-1:0]        cur;
    logic [TAP_W-1:0]        tap_k, rd;
    logic signed [ACC_W-1:0] push_val, mac_res;
    logic signed [OUT_W-1:0] rnd;

    logic              commit, coef_hit, stg_hit;
    logic [ADDR_W-1:0] stg_off;
    logic [TAP_W-1:0]  cur_taps, cur_base, idx_new;
    logic [LOG_W-1:0]  cur_log;
    logic [PH_W:0]     ph_lim;
    logic              fire, last_tap, last_stg, in_mac;

    assign commit   = cfg_we && (cfg_addr == A_CTRL);
    assign coef_hit = cfg_we && (cfg_addr < ADDR_W'(TAP_MAX));
    assign stg_off  = cfg_addr - A_STG;
    assign stg_hit  = cfg_we && (cfg_addr >= A_STG) && (stg_off < ADDR_W'(STG_MAX));

    assign cur_taps = taps_a[cur];
    assign cur_base = base_a[cur];
    assign cur_log  = log_a[cur];
    assign ph_lim   = (PH_W+1)'(1) << cur_log;
    assign fire     = ({1'b0, phase[cur]} + (PH_W+1)'(1)) == ph_lim;
    assign idx_new  = (newest[cur] == cur_taps - TAP_W'(1)) ? '0 : newest[cur] + TAP_W'(1);
    assign last_tap = (tap_k == cur_taps - TAP_W'(1));
    assign last_stg = (cur == n_a - CNT_W'(1));
    assign in_mac   = (state == ST_MAC);

    dfir_cfg_check #(
        .STG_MAX(STG_MAX), .TAP_MAX(TAP_MAX), .TAP_W(TAP_W),
        .LOG_W(LOG_W), .LOG_MAX(LOG_MAX), .CNT_W(CNT_W)
    ) u_check (
        .n_stg(n_w), .taps(taps_w), .dlog(log_w), .base(base_c), .ok(cfg_ok)
    );

    dfir_mac #(.SMP_W(ACC_W), .COEF_W(COEF_W), .GUARD(8)) u_mac (
        .clk(clk), .rst_n(rst_n),
        .clear(state == ST_PUSH), .en(in_mac),
        .smp(hist[TAP_W'(cur_base + rd)]),
        .coef(coef_mem[TAP_W'(cur_base + tap_k)]),
        .result(mac_res)
    );

    dfir_round_sat #(.ACC_W(ACC_W), .OUT_W(OUT_W)) u_rnd (
        .din(mac_res), .dout(rnd)
    );

    // configuration registers
    always_ff @(posedge clk) begin
        if (coef_hit) begin
            coef_mem[cfg_addr[TAP_W-1:0]] <= cfg_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            taps_w <= '0;
            log_w  <= '0;
            n_w    <= '0;
        end else begin
            if (stg_hit) begin
                taps_w[stg_off] <= cfg_data[TAP_W-1:0];
                log_w[stg_off]  <= cfg_data[8 +: LOG_W];
            end
            if (commit) begin
                n_w <= cfg_data[CNT_W-1:0];
            end
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_UNCFG;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ST_UNCFG: nxt = ST_UNCFG;
            ST_FAULT: nxt = ST_FAULT;
            ST_CHECK: nxt = cfg_ok ? ST_WAIT : ST_FAULT;
            ST_WAIT:  nxt = in_valid ? ST_PUSH : ST_WAIT;
            ST_PUSH:  nxt = fire ? ST_MAC : ST_WAIT;
            ST_MAC:   nxt = last_tap ? ST_EMIT : ST_MAC;
            ST_EMIT:  nxt = last_stg ? ST_WAIT : ST_PUSH;
            default:  nxt = ST_UNCFG;
        endcase
        if (commit) nxt = ST_CHECK;
    end

    // datapath sequencing
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            taps_a   <= '0;
            base_a   <= '0;
            log_a    <= '0;
            n_a      <= '0;
            cur      <= '0;
            tap_k    <= '0;
            rd       <= '0;
            push_val <= '0;
            for (int i = 0; i < TAP_MAX; i++) hist[i] <= '0;
            for (int s = 0; s < STG_MAX; s++) begin
                newest[s] <= '0;
                phase[s]  <= '0;
            end
        end else begin
            unique case (state)
                ST_CHECK: begin
                    if (cfg_ok) begin
                        taps_a <= taps_w;
                        base_a <= base_c;
                        log_a  <= log_w;
                        n_a    <= n_w;
                        for (int i = 0; i < TAP_MAX; i++) hist[i] <= '0;
                        for (int s = 0; s < STG_MAX; s++) begin
                            newest[s] <= '0;
                            phase[s]  <= '0;
                        end
                    end
                end
                ST_WAIT: begin
                    if (in_valid) begin
                        push_val <= {in_data, {IN_SH{1'b0}}};
                        cur      <= '0;
                    end
                end
                ST_PUSH: begin
                    hist[TAP_W'(cur_base + idx_new)] <= push_val;
                    newest[cur] <= idx_new;
                    phase[cur]  <= fire ? '0 : phase[cur] + PH_W'(1);
                    tap_k       <= '0;
                    rd          <= idx_new;
                end
                ST_MAC: begin
                    tap_k <= tap_k + TAP_W'(1);
                    rd    <= (rd == '0) ? cur_taps - TAP_W'(1) : rd - TAP_W'(1);
                end
                ST_EMIT: begin
                    push_val <= mac_res;
                    cur      <= cur + CNT_W'(1);
                end
                default: ;
            endcase
        end
    end

    // outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_data  <= '0;
            cfg_err   <= 1'b0;
        end else begin
            out_valid <= (state == ST_EMIT) && last_stg;
            if ((state == ST_EMIT) && last_stg) begin
                out_data <= rnd;
            end
            cfg_err <= (nxt == ST_FAULT);
        end
    end
endmodule

// File: rtl/dfir_decim_engine_chk.sv
module dfir_decim_engine_chk #(
    parameter int OUT_W = 16,
    parameter int TAP_W = 7
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cfg_we,
    input logic [7:0]       cfg_addr,
    input logic             out_valid,
    input logic [OUT_W-1:0] out_data,
    input logic             cfg_err,
    input logic             in_mac,
    input logic [TAP_W-1:0] tap_k,
    input logic [TAP_W-1:0] cur_taps
);
    logic commit;
    assign commit = cfg_we && (cfg_addr == dfir_pkg::A_CTRL);

    // R11
    strobe_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |=> !out_valid);

    // R11
    word_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> $stable(out_data));

    // R3
    fault_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err |-> !out_valid);

    // R3
    fault_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_err && !commit) |=> cfg_err);

    // R6
    tap_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_mac |-> (tap_k < cur_taps));
endmodule

bind dfir_decim_engine dfir_decim_engine_chk #(.OUT_W(OUT_W), .TAP_W(TAP_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .out_valid(out_valid), .out_data(out_data), .cfg_err(cfg_err),
    .in_mac(in_mac), .tap_k(tap_k), .cur_taps(cur_taps)
);

// File: tb/tb_dfir_decim_engine.sv
`timescale 1ns/1ps
module tb_dfir_decim_engine;
    localparam int GAP = 24;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [7:0]  cfg_addr = '0;
    logic [23:0] cfg_data = '0;
    logic        in_valid = 1'b0;
    logic signed [15:0] in_data = '0;
    logic        out_valid;
    logic signed [15:0] out_data;
    logic        cfg_err;

    int n_chk = 0;
    int n_err = 0;
    int ncap = 0;
    int cap [64];
    int pulse_bad = 0;
    int hold_bad = 0;
    logic prev_v = 1'b0;
    logic signed [15:0] prev_d = '0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    dfir_decim_engine dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_data(cfg_data), .in_valid(in_valid), .in_data(in_data),
        .out_valid(out_valid), .out_data(out_data), .cfg_err(cfg_err)
    );

    always @(negedge clk) begin
        if (rst_n) begin
            if (out_valid) begin
                if (ncap < 64) cap[ncap] = int'(out_data);
                ncap++;
                if (prev_v) pulse_bad++;
            end else if (out_data !== prev_d) begin
                hold_bad++;
            end
            prev_v = out_valid;
            prev_d = out_data;
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wr(input int addr, input int data);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = 8'(addr); cfg_data = 24'(data);
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic set_stage(input int s, input int taps, input int lg);
        wr(8'h80 + s, (lg << 8) | taps);
    endtask

    task automatic commit(input int n);
        wr(8'hC0, n);
        repeat (3) @(negedge clk);
    endtask

    task automatic send(input int v);
        @(negedge clk);
        in_valid = 1'b1; in_data = 16'(v);
        @(negedge clk);
        in_valid = 1'b0;
        repeat (GAP) @(negedge clk);
    endtask

    task automatic clear_cap();
        @(posedge clk);
        ncap = 0;
    endtask

    task automatic t_reset();
        chk("R1 out_valid after reset", int'(out_valid), 0);
        chk("R1 out_data after reset", int'(out_data), 0);
        chk("R1 cfg_err after reset", int'(cfg_err), 0);
        clear_cap();
        send(100); send(200); send(300); send(400);
        chk("R1 no output unconfigured", ncap, 0);
    endtask

    task automatic t_single_tap();
        wr(0, 24'h400000);
        set_stage(0, 1, 1);
        commit(1);
        chk("R4 cfg_err clear on accept", int'(cfg_err), 0);
        clear_cap();
        send(2); send(4);
        chk("R5 one word after two samples", ncap, 1);
        send(6); send(8);
        chk("R2 R5 word count", ncap, 2);
        chk("R7 first word", cap[0], 2);
        chk("R7 second word", cap[1], 4);
    endtask

    task automatic t_rounding();
        commit(1);
        clear_cap();
        send(0); send(1); send(0); send(-1); send(0); send(3);
        chk("R8 word count", ncap, 3);
        chk("R8 half rounds up positive", cap[0], 1);
        chk("R8 half rounds up negative", cap[1], 0);
        chk("R8 one and a half", cap[2], 2);
    endtask

    task automatic t_saturate();
        wr(0, 24'h600000); wr(1, 24'h600000);
        set_stage(0, 2, 1);
        commit(1);
        clear_cap();
        for (int i = 0; i < 4; i++) send(32767);
        for (int i = 0; i < 5; i++) send(-32768);
        chk("R9 word count", ncap, 4);
        chk("R9 positive clamp a", cap[0], 32767);
        chk("R9 positive clamp b", cap[1], 32767);
        chk("R7 R9 negative clamp a", cap[2], -32768);
        chk("R7 R9 negative clamp b", cap[3], -32768);
    endtask

    task automatic t_taps_order();
        wr(0, 24'h400000); wr(1, 24'h200000); wr(2, 24'h100000);
        set_stage(0, 3, 1);
        commit(1);
        clear_cap();
        send(4);
        chk("R4 phase restarted", ncap, 0);
        send(8); send(12); send(16);
        chk("R6 word count", ncap, 2);
        chk("R4 R6 cleared history", cap[0], 5);
        chk("R6 three taps newest first", cap[1], 12);
    endtask

    task automatic t_cascade();
        wr(0, 24'h400000); wr(1, 24'h400000);
        set_stage(0, 1, 1); set_stage(1, 1, 1);
        commit(2);
        chk("R10 two-stage accepted", int'(cfg_err), 0);
        clear_cap();
        for (int i = 0; i < 4; i++) send(8);
        for (int i = 0; i < 4; i++) send(16);
        chk("R10 two-stage word count", ncap, 2);
        chk("R10 two-stage word a", cap[0], 2);
        chk("R6 R10 two-stage word b", cap[1], 4);
    endtask

    task automatic t_five_stage();
        for (int s = 0; s < 5; s++) begin
            wr(s, 24'h400000);
            set_stage(s, 1, 1);
        end
        commit(5);
        chk("R10 five-stage accepted", int'(cfg_err), 0);
        clear_cap();
        for (int i = 0; i < 31; i++) send(64);
        chk("R10 no word before 32nd sample", ncap, 0);
        send(64);
        chk("R10 five-stage word count", ncap, 1);
        chk("R10 five-stage value", cap[0], 2);
    endtask

    task automatic reject(input string tag, input int n);
        commit(n);
        chk(tag, int'(cfg_err), 1);
    endtask

    task automatic t_reject();
        set_stage(0, 1, 1);
        reject("R3 zero stage count", 0);
        reject("R3 six stages", 6);
        set_stage(0, 1, 1); set_stage(1, 0, 0);
        reject("R3 empty active stage", 2);
        set_stage(0, 100, 1); set_stage(1, 9, 0);
        reject("R3 109 taps", 2);
        clear_cap();
        send(5); send(5);
        chk("R3 samples ignored in fault", ncap, 0);
        chk("R3 flag held", int'(cfg_err), 1);
        set_stage(1, 8, 0);
        commit(2);
        chk("R3 108 taps accepted", int'(cfg_err), 0);
        set_stage(0, 1, 8); set_stage(1, 1, 1);
        reject("R3 decimation 512", 2);
        set_stage(0, 1, 0);
        reject("R3 decimation 1", 1);
    endtask

    task automatic t_max_decim();
        wr(0, 24'h400000);
        set_stage(0, 1, 8);
        commit(1);
        chk("R4 R5 decimation 256 accepted", int'(cfg_err), 0);
        clear_cap();
        for (int i = 0; i < 255; i++) send(2);
        chk("R5 no word before 256th sample", ncap, 0);
        send(2);
        chk("R5 decimation 256 count", ncap, 1);
        chk("R5 decimation 256 value", cap[0], 1);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_single_tap();
        t_rounding();
        t_saturate();
        t_taps_order();
        t_cascade();
        t_five_stage();
        t_reject();
        t_max_decim();
        chk("R11 strobe longer than one cycle", pulse_bad, 0);
        chk("R11 data changed without strobe", hold_bad, 0);
        if (!finished) begin
            finished = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_chk++;
            n_err++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end
endmodule